// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Controller

This block runs a three-phase trapezoidal brushless DC motor from three digital Hall sensor signals. The Hall lines are brought into the clock domain through two flip-flops and filtered: a new three-bit code is taken as the rotor position only after it has held steady for a set number of clocks. The accepted code selects one of six 120-degree drive steps. Each step switches on the high-side switch of one phase and the low-side switch of another. The third phase floats.

A PWM input chops the high-side switch of the energised pair, and the low-side switch stays on. A direction input turns the rotation around. An active-low brake input shorts the motor windings through the three low-side switches. An enable input puts the block to sleep with every switch off. A tachometer output changes level on each accepted Hall step, so its frequency follows the commutation rate. All gate outputs and the tachometer are registered.

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted, all six gate outputs and the tachometer output are low.
- R2: A Hall code first sampled on rising edge k becomes the accepted position on edge k+STABLE_CYCLES+2. The tachometer toggles on that edge, and the gate outputs reflect the new position on edge k+STABLE_CYCLES+3.
- R3: A Hall code that is sampled unchanged on STABLE_CYCLES or fewer consecutive rising edges is ignored. The tachometer and the gates keep their previous values.
- R4: The Hall code is {hallIn[2],hallIn[1],hallIn[0]} and phase bits are A=bit0, B=bit1, C=bit2. With dirFwd=1, enable=1, brakeN=1 and pwmIn=1, the codes map to high/low phase pairs as follows: 001 gives A/B, 011 gives A/C, 010 gives B/C, 110 gives B/A, 100 gives C/A and 101 gives C/B.
- R5: With dirFwd=0, each code energises the same two phases as in R4, with the high and low sides exchanged.
- R6: When pwmIn is low, every high-side output is off on the next edge. The low-side output of the active pair stays on.
- R7: The accepted codes 000 and 111 switch all six gate outputs off.
- R8: While brakeN is low and enable is high, all three low-side outputs are on and all high-side outputs are off, whatever the Hall code.
- R9: While enable is low, all six gate outputs are off. This takes priority over brake.
- R10: The tachometer toggles exactly once for each accepted change of Hall code, including changes to and from invalid codes.
- R11: The high-side and low-side outputs of one phase are never on together, and no more than one high-side output is ever on at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Low puts the block to sleep with all gates off |
| hallIn | input | 3 | Raw Hall sensor levels, bit0 = phase A |
| pwmIn | input | 1 | PWM chop applied to the active high-side switch |
| dirFwd | input | 1 | 1 = forward sequence, 0 = reversed |
| brakeN | input | 1 | Active-low brake request |
| gateHi | output | 3 | High-side gate enables, bit0 = phase A |
| gateLo | output | 3 | Low-side gate enables, bit0 = phase A |
| tachOut | output | 1 | Toggles on each accepted Hall step |

## Verification
The hardest case to reach from the ports is the filter boundary. A code must be accepted after exactly STABLE_CYCLES+1 steady samples and ignored after STABLE_CYCLES samples, and the two-flop delay hides exactly when the count starts. The stimulus holds a spurious code for exactly STABLE_CYCLES clocks, and then for one clock more. It also times one clean change edge by edge, so that both the tachometer edge and the gate edge are pinned to their exact clock. A behavioural model built on the history of sampled inputs follows every cycle and catches any difference of one clock.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int PHASES = 3;

  // Strobes passed from the Hall control to the gate datapath
  typedef struct packed {
    logic                step;       // an accepted change of Hall code this cycle
    logic [PHASES-1:0]   hallState;  // currently accepted Hall code
  } hallStrobe_t;
endpackage

// File: rtl/bldc_hall_filter.sv
module bldc_hall_filter
  import bldc_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hallIn,
  output hallStrobe_t       strobe
);
  localparam int CNT_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STABLE_CYCLES - 1);

  logic [PHASES-1:0] syncA, syncB, candCode, accCode;
  logic [CNT_W-1:0]  runCnt;
  logic              accept;

  // A candidate is accepted once it has stayed on syncB long enough
  always_comb accept = (syncB == candCode) && (candCode != accCode) && (runCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      candCode <= '0;
      accCode  <= '0;
      runCnt   <= '0;
    end else begin
      syncA <= hallIn;
      syncB <= syncA;
      if (syncB != candCode) begin
        candCode <= syncB;
        runCnt   <= '0;
      end else if (candCode != accCode) begin
        if (accept) accCode <= candCode;
        else        runCnt  <= runCnt + 1'b1;
      end
    end
  end

  assign strobe.step      = accept;
  assign strobe.hallState = accCode;

  // R2/R3: a new accepted code must equal the synchronised value that completed its run
  p_accept_after_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accCode != $past(accCode)) |-> ($past(syncB) == accCode && $past(runCnt) == LAST_CNT));

  // R10: the step strobe and a change of the accepted code go together
  p_step_changes_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (accCode != $past(accCode)));
endmodule

// File: rtl/bldc_gate_drive.sv
module bldc_gate_drive
  import bldc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hallStrobe_t       strobe,
  input  logic              enable,
  input  logic              pwmIn,
  input  logic              dirFwd,
  input  logic              brakeN,
  output logic [PHASES-1:0] gateHi,
  output logic [PHASES-1:0] gateLo,
  output logic              tachOut
);
  logic [PHASES-1:0] hiSel, loSel, hiNext, loNext;
  logic              codeValid;

  // Six-step table, forward sense: one phase sourcing, one sinking
  always_comb begin
    hiSel     = '0;
    loSel     = '0;
    codeValid = 1'b1;
    case (strobe.hallState)
      3'b001:  begin hiSel = 3'b001; loSel = 3'b010; end
      3'b011:  begin hiSel = 3'b001; loSel = 3'b100; end
      3'b010:  begin hiSel = 3'b010; loSel = 3'b100; end
      3'b110:  begin hiSel = 3'b010; loSel = 3'b001; end
      3'b100:  begin hiSel = 3'b100; loSel = 3'b001; end
      3'b101:  begin hiSel = 3'b100; loSel = 3'b010; end
      default: codeValid = 1'b0;
    endcase
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic wantHi, wantLo;
    assign wantHi    = dirFwd ? hiSel[p] : loSel[p];
    assign wantLo    = dirFwd ? loSel[p] : hiSel[p];
    assign hiNext[p] = enable && brakeN && codeValid && pwmIn && wantHi;
    assign loNext[p] = enable && (!brakeN || (codeValid && wantLo));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateHi  <= '0;
      gateLo  <= '0;
      tachOut <= 1'b0;
    end else begin
      gateHi  <= hiNext;
      gateLo  <= loNext;
      tachOut <= tachOut ^ strobe.step;
    end
  end

  p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((gateHi & gateLo) == '0) && $onehot0(gateHi));

  p_single_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && brakeN) |=> ($onehot0(gateHi) && $onehot0(gateLo)));

  p_pwm_chop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && brakeN && !pwmIn) |=> (gateHi == '0));

  p_invalid_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (brakeN && (strobe.hallState == 3'b000 || strobe.hallState == 3'b111))
      |=> (gateHi == '0 && gateLo == '0));

  p_brake_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !brakeN) |=> (gateLo == '1 && gateHi == '0));

  p_sleep_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (gateHi == '0 && gateLo == '0));

  p_tach_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(tachOut));
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] hallIn,
  input  logic       pwmIn,
  input  logic       dirFwd,
  input  logic       brakeN,
  output logic [2:0] gateHi,
  output logic [2:0] gateLo,
  output logic       tachOut
);
  hallStrobe_t hallStb;

  bldc_hall_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hallIn (hallIn),
    .strobe (hallStb)
  );

  bldc_gate_drive u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (hallStb),
    .enable  (enable),
    .pwmIn   (pwmIn),
    .dirFwd  (dirFwd),
    .brakeN  (brakeN),
    .gateHi  (gateHi),
    .gateLo  (gateLo),
    .tachOut (tachOut)
  );
endmodule

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [2:0] hallIn = 3'b000;
  logic pwmIn = 1'b1;
  logic dirFwd = 1'b1;
  logic brakeN = 1'b1;
  logic [2:0] gateHi, gateLo;
  logic tachOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string sect = "R1";

  bldc_commutator #(.STABLE_CYCLES(N)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .hallIn(hallIn), .pwmIn(pwmIn),
    .dirFwd(dirFwd), .brakeN(brakeN), .gateHi(gateHi), .gateLo(gateLo), .tachOut(tachOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int seqCodes [6] = '{1, 3, 2, 6, 4, 5};
  int hist[$];
  int lastV, run, accM;
  bit tachM;
  logic [2:0] expHi, expLo;
  bit started = 0;

  function automatic void driveFor(int code, output logic [2:0] hi, output logic [2:0] lo);
    int k, h, l, t;
    hi = 3'b000; lo = 3'b000; k = -1;
    if (!enable) return;
    if (!brakeN) begin lo = 3'b111; return; end
    for (int i = 0; i < 6; i++) if (seqCodes[i] == code) k = i;
    if (k < 0) return;
    h = k / 2;
    l = ((k + 1) / 2 + 1) % 3;
    if (!dirFwd) begin t = h; h = l; l = t; end
    if (pwmIn) hi = 3'(1 << h);
    lo = 3'(1 << l);
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      hist = {0, 0};
      lastV = 0; run = 100; accM = 0; tachM = 0;
      expHi = 0; expLo = 0;
    end else begin
      int v;
      driveFor(accM, expHi, expLo);
      v = hist[0];
      if (v == lastV) begin if (run < 100) run++; end
      else run = 1;
      lastV = v;
      if (run >= N + 1 && v != accM) begin accM = v; tachM = ~tachM; end
      hist.push_back(int'(hallIn));
      void'(hist.pop_front());
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) if (started) begin
    chk(gateHi == expHi, sect, "gateHi", gateHi, expHi);
    chk(gateLo == expLo, sect, "gateLo", gateLo, expLo);
    chk(tachOut == tachM, "R10", "tachOut", tachOut, tachM);
    chk(((gateHi & gateLo) == 0) && ($countones(gateHi) <= 1), "R11", "shoot-through", {gateHi, gateLo}, 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hold(input logic [2:0] code, input int n);
    @(negedge clk) hallIn = code;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    sect = "R1";
    repeat (4) @(negedge clk);
    chk(gateHi == 0 && gateLo == 0, "R1", "gates in reset", {gateHi, gateLo}, 0);
    chk(tachOut == 0, "R1", "tach in reset", tachOut, 0);
    rstN = 1; enable = 1;

    sect = "R4";
    for (int r = 0; r < 2; r++)
      foreach (seqCodes[i]) hold(3'(seqCodes[i]), N + 8);

    sect = "R6";
    hold(3'b011, N + 8);
    for (int i = 0; i < 20; i++) begin @(negedge clk) pwmIn = (i % 3) != 0; end
    @(negedge clk) pwmIn = 1;

    sect = "R5";
    dirFwd = 0;
    for (int i = 5; i >= 0; i--) hold(3'(seqCodes[i]), N + 8);
    for (int i = 0; i < 12; i++) begin @(negedge clk) pwmIn = i[0]; end
    @(negedge clk) pwmIn = 1; dirFwd = 1;

    sect = "R2";
    hold(3'b001, N + 8);
    begin
      logic t0; logic [2:0] g0;
      @(negedge clk) hallIn = 3'b011;
      t0 = tachOut; g0 = gateLo;
      for (int i = 1; i <= N + 4; i++) begin
        @(negedge clk);
        if (i == N + 2) chk(tachOut == t0, "R2", "tach before acceptance", tachOut, t0);
        if (i == N + 3) begin
          chk(tachOut != t0, "R2", "tach at acceptance", tachOut, ~t0);
          chk(gateLo == g0, "R2", "gates one edge after acceptance", gateLo, g0);
        end
        if (i == N + 4) chk(gateLo == 3'b100, "R2", "gateLo after latency", gateLo, 3'b100);
      end
    end

    sect = "R3";
    hold(3'b011, N + 8);
    begin
      logic t0;
      t0 = tachOut;
      hold(3'b010, N);      // exactly N samples: ignored
      hold(3'b011, N + 6);
      chk(tachOut == t0, "R3", "tach after N-sample glitch", tachOut, t0);
      chk(gateLo == 3'b100, "R3", "gates after N-sample glitch", gateLo, 3'b100);
      hold(3'b110, 1);
      hold(3'b011, N + 6);
      chk(tachOut == t0, "R3", "tach after one-sample glitch", tachOut, t0);
      hold(3'b010, N + 1);  // N+1 samples: accepted
      hold(3'b011, N + 8);
      chk(tachOut == t0, "R3", "tach after two accepted steps", tachOut, t0);
    end

    sect = "R7";
    hold(3'b000, N + 8);
    chk(gateHi == 0 && gateLo == 0, "R7", "code 000", {gateHi, gateLo}, 0);
    hold(3'b111, N + 8);
    chk(gateHi == 0 && gateLo == 0, "R7", "code 111", {gateHi, gateLo}, 0);
    hold(3'b110, N + 8);

    sect = "R8";
    @(negedge clk) brakeN = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk) pwmIn = i[1]; end
    hold(3'b101, N + 8);
    chk(gateLo == 3'b111 && gateHi == 0, "R8", "brake", {gateHi, gateLo}, 3'b000111);
    pwmIn = 1;

    sect = "R9";
    @(negedge clk) enable = 0;
    hold(3'b001, N + 8);
    chk(gateHi == 0 && gateLo == 0, "R9", "sleep with brake", {gateHi, gateLo}, 0);
    @(negedge clk) brakeN = 1;
    hold(3'b011, N + 6);
    chk(gateHi == 0 && gateLo == 0, "R9", "sleep", {gateHi, gateLo}, 0);
    @(negedge clk) enable = 1;
    sect = "R4";
    hold(3'b010, N + 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule